// File: doc/BRIEF.md
# Dual Programmable Baud Rate Generator

This block contains two independent rate dividers that turn a slow input clock, presented as a one-cycle strobe in the system clock domain, into a stream of one-cycle output ticks. Each divider has a 16-bit time constant and a 16-bit down-counter. It emits one tick for every (time constant + 1) accepted strobes. A divider can either reload itself and run without end, or stop after one terminal count until software reloads it.

Software reaches the block through a small register port. It writes time constants, per-divider control bits (run enable, one-shot mode, readback select) and a sticky terminal-count status word that is cleared by writing 1. A separate load-command input copies the time constants into one or both counters. The same command restarts a divider that has stopped in one-shot mode. Reading a time constant address returns either the value last written or a snapshot of the live counter taken when the select bit was written as 1.

Top module: `dual_baud_gen`

## Requirements
- R1: With the enable bit set and auto-reload mode, after a load a divider emits exactly floor(S/(T+1)) ticks for S accepted strobes, where T is its time constant: T=0 gives a tick on every strobe, and T=0xFFFF gives the first tick on strobe 65,536. Each tick is one cycle wide and appears in the cycle after the strobe that causes it.
- R2: While a divider's enable bit is 0, strobes neither tick nor change its counter. After re-enabling, it resumes counting from the held value.
- R3: A terminal count sets that divider's status bit, bit i at address 3. The bit stays set until a write to address 3 carries a 1 in bit i. Writing 0 there has no effect.
- R4: With the one-shot bit set, a divider ticks once on its terminal count and then stays stopped with its counter at 0. Further strobes have no effect.
- R5: Bit i of `load_cmd` copies time constant i into counter i and clears any one-shot stop. Value 1 loads divider 0, value 2 loads divider 1, and value 3 loads both.
- R6: The time constant of divider i is written at address i (0 or 1). With its select bit at 0, reading address i returns the last value written there. Read data appears one cycle after `rd_addr` is presented.
- R7: The control register is at address 2. For divider i the enable bit is at 4i, the one-shot bit at 4i+1 and the readback select bit at 4i+2. A control write with select i at 1 captures counter i, and reads of address i then return that snapshot. The snapshot does not follow the counter until select is written as 1 again.
- R8: A load command in the same cycle as an accepted strobe wins: the counter takes the time constant, is not decremented, and no tick is issued.
- R9: After reset, all time constants, counters, control bits, status bits and read data are 0, and no ticks are issued.
- R10: If a terminal count and a write-1-to-clear of the same status bit occur in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_stb | input | NGEN (2) | Per-divider input clock event, one cycle wide |
| load_cmd | input | NGEN (2) | Per-divider load request (1, 2 or 3) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (2) | Register write address |
| wr_data | input | CW (16) | Register write data |
| rd_addr | input | AW (2) | Register read address |
| rd_data | output | CW (16) | Registered read data, one cycle after `rd_addr` |
| tick | output | NGEN (2) | Per-divider output tick, one cycle wide |

## Verification
The assertions assume that reset is applied before any strobe, write or load, and that each strobe and each load request lasts exactly one system clock. They also assume that a captured snapshot is only compared against the counter state of the cycle in which the control write lands. The stimulus drives every input on the falling edge for exactly one cycle. It keeps one-shot and enable changes to points where no strobe is pending. It issues overlapping load/strobe and set/clear events only in the dedicated priority cases, so each checked count follows from floor arithmetic over a known number of strobes.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

  // Per-divider control field; bit order inside the field is the register layout
  typedef struct packed {
    logic sel;     // bit 2: readback selects snapshot
    logic single;  // bit 1: one-shot mode
    logic en;      // bit 0: run enable
  } gen_ctrl_t;

  localparam int CTRL_STRIDE = 4;
  localparam int CTRL_BITS   = 3;

endpackage

// File: rtl/bgen_counter.sv
module bgen_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_stb,
  input  logic          en,
  input  logic          single,
  input  logic          load,
  input  logic [CW-1:0] tc,
  output logic [CW-1:0] cnt,
  output logic          zero_evt,
  output logic          tick
);

  logic stopped;
  logic active;

  // A strobe is consumed only when running; a load in the same cycle wins
  assign active   = in_stb && en && !stopped && !load;
  assign zero_evt = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      stopped <= 1'b0;
      tick    <= 1'b0;
    end else begin
      tick <= zero_evt;
      if (load) begin
        cnt     <= tc;
        stopped <= 1'b0;
      end else if (active) begin
        if (cnt == '0) begin
          if (single) stopped <= 1'b1;
          else        cnt     <= tc;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(cnt)); // R2
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(tc))); // R5
  AST_LOAD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    load |=> !tick); // R8
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stopped && !load) |=> (cnt == '0 && !tick)); // R4
  AST_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    tick |-> ($past(cnt) == '0)); // R1

endmodule

// File: rtl/bgen_regs.sv
module bgen_regs
  import bgen_pkg::*;
#(
  parameter int NGEN = 2,
  parameter int CW   = 16,
  parameter int AW   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [CW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  input  logic [NGEN*CW-1:0]   cnt_flat,
  input  logic [NGEN-1:0]      zero_evt,
  output logic [NGEN*CW-1:0]   tc_flat,
  output logic [NGEN-1:0]      en,
  output logic [NGEN-1:0]      single,
  output logic [CW-1:0]        rd_data
);

  localparam int CTRL_ADDR = NGEN;
  localparam int STAT_ADDR = NGEN + 1;

  logic [NGEN-1:0][CW-1:0] tc_q;
  logic [NGEN-1:0][CW-1:0] snap_q;
  gen_ctrl_t [NGEN-1:0]    ctrl_q;
  logic [NGEN-1:0]         flag_q;
  logic [CW-1:0]           rd_next;

  logic ctrl_wr;
  logic stat_wr;
  assign ctrl_wr = wr_en && (wr_addr == AW'(CTRL_ADDR));
  assign stat_wr = wr_en && (wr_addr == AW'(STAT_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q   <= '0;
      snap_q <= '0;
      ctrl_q <= '0;
      flag_q <= '0;
    end else begin
      for (int i = 0; i < NGEN; i++) begin
        if (wr_en && (wr_addr == AW'(i)))
          tc_q[i] <= wr_data;
        if (ctrl_wr) begin
          ctrl_q[i] <= wr_data[CTRL_STRIDE*i +: CTRL_BITS];
          if (wr_data[CTRL_STRIDE*i + 2])
            snap_q[i] <= cnt_flat[CW*i +: CW];
        end
        if (zero_evt[i])
          flag_q[i] <= 1'b1;
        else if (stat_wr && wr_data[i])
          flag_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NGEN; i++) begin
      if (rd_addr == AW'(i))
        rd_next = ctrl_q[i].sel ? snap_q[i] : tc_q[i];
    end
    if (rd_addr == AW'(CTRL_ADDR)) begin
      for (int i = 0; i < NGEN; i++)
        rd_next[CTRL_STRIDE*i +: CTRL_BITS] = ctrl_q[i];
    end
    if (rd_addr == AW'(STAT_ADDR))
      rd_next[NGEN-1:0] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  for (genvar g = 0; g < NGEN; g++) begin : g_out
    assign tc_flat[CW*g +: CW] = tc_q[g];
    assign en[g]               = ctrl_q[g].en;
    assign single[g]           = ctrl_q[g].single;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
      zero_evt[g] |=> flag_q[g]); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag_q[g] && !(stat_wr && wr_data[g])) |=> flag_q[g]); // R3
    AST_TC_HELD: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (wr_addr == AW'(g))) |=> $stable(tc_q[g])); // R6
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
      !(ctrl_wr && wr_data[CTRL_STRIDE*g + 2]) |=> $stable(snap_q[g])); // R7
  end

endmodule

// File: rtl/dual_baud_gen.sv
module dual_baud_gen #(
  parameter int NGEN = 2,
  parameter int CW   = 16,
  parameter int AW   = $clog2(NGEN + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NGEN-1:0] in_stb,
  input  logic [NGEN-1:0] load_cmd,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [CW-1:0]   rd_data,
  output logic [NGEN-1:0] tick
);

  logic [NGEN*CW-1:0] cnt_flat;
  logic [NGEN*CW-1:0] tc_flat;
  logic [NGEN-1:0]    zero_evt;
  logic [NGEN-1:0]    en;
  logic [NGEN-1:0]    single;

  bgen_regs #(.NGEN(NGEN), .CW(CW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .cnt_flat (cnt_flat),
    .zero_evt (zero_evt),
    .tc_flat  (tc_flat),
    .en       (en),
    .single   (single),
    .rd_data  (rd_data)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_div
    bgen_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .in_stb   (in_stb[g]),
      .en       (en[g]),
      .single   (single[g]),
      .load     (load_cmd[g]),
      .tc       (tc_flat[CW*g +: CW]),
      .cnt      (cnt_flat[CW*g +: CW]),
      .zero_evt (zero_evt[g]),
      .tick     (tick[g])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (tick == '0 && rd_data == '0)); // R9

endmodule

// File: tb/dual_baud_gen_test.sv
module dual_baud_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  in_stb = '0;
  logic [1:0]  load_cmd = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  tick;

  int total = 0;
  int bad = 0;
  int ticks0 = 0;
  int ticks1 = 0;
  logic [15:0] v;

  dual_baud_gen uut (
    .clk(clk), .rst(rst), .in_stb(in_stb), .load_cmd(load_cmd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      ticks0 += int'(tick[0]);
      ticks1 += int'(tick[1]);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic ld(input logic [1:0] m);
    @(negedge clk); load_cmd = m;
    @(negedge clk); load_cmd = '0;
  endtask

  task automatic stb(input logic [1:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); in_stb = m;
    end
    @(negedge clk); in_stb = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic zero_counts();
    @(negedge clk); ticks0 = 0; ticks1 = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: reset state at the ports
    check("R9 tick", int'(tick), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R9 reg", int'(v), 0);
    end

    // R1: sweep of small time constants on both dividers
    for (int k = 0; k < 10; k++) begin
      int t0 = k;
      int t1 = (k * 3) % 10;
      wr(2'd0, 16'(t0));
      wr(2'd1, 16'(t1));
      wr(2'd2, 16'h0011);
      ld(2'b11);
      zero_counts();
      stb(2'b11, 60);
      check("R1 div0", ticks0, 60 / (t0 + 1));
      check("R1 div1", ticks1, 60 / (t1 + 1));
    end

    // R1: largest time constant
    wr(2'd0, 16'hFFFF);
    wr(2'd2, 16'h0001);
    ld(2'b01);
    zero_counts();
    stb(2'b01, 65535);
    check("R1 max before", ticks0, 0);
    stb(2'b01, 1);
    check("R1 max edge", ticks0, 1);

    // R2: disabled divider holds
    wr(2'd0, 16'd5);
    wr(2'd2, 16'h0000);
    ld(2'b01);
    zero_counts();
    stb(2'b01, 20);
    check("R2 no tick", ticks0, 0);
    wr(2'd2, 16'h0004);
    rd(2'd0, v);
    check("R2 held cnt", int'(v), 5);
    wr(2'd2, 16'h0001);
    stb(2'b01, 5);
    check("R2 resume early", ticks0, 0);
    stb(2'b01, 1);
    check("R2 resume tick", ticks0, 1);

    // R3: sticky status, write-1-to-clear per bit
    rd(2'd3, v);
    check("R3 both set", int'(v), 3);
    wr(2'd3, 16'h0000);
    rd(2'd3, v);
    check("R3 write0 ignored", int'(v), 3);
    wr(2'd3, 16'h0001);
    rd(2'd3, v);
    check("R3 clear bit0", int'(v), 2);
    wr(2'd3, 16'h0002);
    rd(2'd3, v);
    check("R3 clear bit1", int'(v), 0);

    // R4: one-shot stops at zero
    wr(2'd0, 16'd3);
    wr(2'd2, 16'h0003);
    ld(2'b01);
    zero_counts();
    stb(2'b01, 20);
    check("R4 single tick", ticks0, 1);
    wr(2'd2, 16'h0007);
    rd(2'd0, v);
    check("R4 stopped cnt", int'(v), 0);
    rd(2'd3, v);
    check("R4 status", int'(v), 1);

    // R5: load restarts, per-divider and both
    ld(2'b01);
    stb(2'b01, 3);
    check("R5 restart early", ticks0, 1);
    stb(2'b01, 1);
    check("R5 restart tick", ticks0, 2);
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd1);
    wr(2'd2, 16'h0033);
    ld(2'b11);
    zero_counts();
    stb(2'b11, 10);
    check("R5 both div0", ticks0, 1);
    check("R5 both div1", ticks1, 1);
    ld(2'b10);
    stb(2'b11, 10);
    check("R5 load1 div0", ticks0, 1);
    check("R5 load1 div1", ticks1, 2);

    // R6: readback of written constant
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'hABCD);
    rd(2'd0, v);
    check("R6 tc0", int'(v), 16'h1234);
    rd(2'd1, v);
    check("R6 tc1", int'(v), 16'hABCD);
    rd(2'd2, v);
    check("R6 ctrl", int'(v), 0);

    // R7: snapshot capture and staleness
    wr(2'd0, 16'd10);
    wr(2'd2, 16'h0001);
    ld(2'b01);
    stb(2'b01, 3);
    wr(2'd2, 16'h0005);
    rd(2'd0, v);
    check("R7 snap", int'(v), 7);
    stb(2'b01, 2);
    rd(2'd0, v);
    check("R7 stale", int'(v), 7);
    wr(2'd2, 16'h0005);
    rd(2'd0, v);
    check("R7 fresh", int'(v), 5);

    // R8: load beats a same-cycle strobe
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'd4);
    ld(2'b01);
    stb(2'b01, 2);
    zero_counts();
    @(negedge clk); in_stb = 2'b01; load_cmd = 2'b01;
    @(negedge clk); in_stb = 2'b00; load_cmd = 2'b00;
    @(negedge clk);
    check("R8 no tick", ticks0, 0);
    wr(2'd2, 16'h0005);
    rd(2'd0, v);
    check("R8 cnt", int'(v), 4);

    // R10: set wins over same-cycle clear
    wr(2'd0, 16'd0);
    wr(2'd2, 16'h0001);
    ld(2'b01);
    wr(2'd3, 16'h0003);
    rd(2'd3, v);
    check("R10 cleared", int'(v), 0);
    @(negedge clk); in_stb = 2'b01; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0001;
    @(negedge clk); in_stb = 2'b00; wr_en = 1'b0;
    rd(2'd3, v);
    check("R10 set wins", int'(v), 1);
    wr(2'd3, 16'h0001);
    rd(2'd3, v);
    check("R10 later clear", int'(v), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule